// File: doc/BRIEF.md
# Circular History Log with Trigger Index

This block keeps a wrap-around log of spatial-region records and a set-associative side index over that log. Each record carries a trigger block address and a fixed-width payload. A record written into the block goes to the current tail slot of the log. The tail then advances. The index is updated so that the record's trigger address points at that slot. Because of this, the index always names the newest log position written for a given trigger.

A second port looks an address up in the index. It answers one cycle later with hit or miss and the log slot number. A third port reads back the record held in any slot, also one cycle later. A client that replays recorded streams uses the lookup to find where a stream starts and the read port to fetch the records from there. Building the records and turning them into prefetches happen outside this block.

The write and lookup ports are valid/ready streams. A write is accepted in every cycle (`wr_ready` is tied high), so a writer never stalls. A lookup is accepted only when no write is offered in the same cycle. A requester that sees `lk_ready` low must hold `lk_valid` and `lk_addr` until a cycle in which `lk_ready` is high. The lookup response and the read port are plain signals with no back-pressure: each is valid for exactly one cycle and must be taken then.

Top module: `trig_history_log`

## Requirements
- R1: An accepted write stores trigger and payload at the tail slot. The tail starts at 0 after reset, advances by one per write, and returns to 0 after slot HB_DEPTH-1.
- R2: A write whose trigger is already in the index re-points that entry to the new slot. A lookup of that trigger then returns the new slot and no second way is used.
- R3: The set is trigger bits [SET_W-1:0] and the tag is the remaining upper bits. A write that misses fills the lowest-numbered empty way of the set. If the set has no empty way, the write replaces the least recently used way.
- R4: An accepted lookup gives `lk_rsp_valid` high for exactly the next cycle, with `lk_rsp_hit` and, on a hit, `lk_rsp_slot`. A miss returns slot 0. Without an accepted lookup, `lk_rsp_valid` stays low.
- R5: A lookup hit makes the entry most recently used, in the same way a write does. A lookup miss changes no replacement state.
- R6: `wr_ready` is always high. `lk_ready` is low in any cycle with `wr_valid` high. A lookup offered in that cycle is not accepted and gives no response.
- R7: Log slots overwritten by wrap-around are not removed from the index. A lookup may return a slot that now holds a different record, and the older record stays readable until its slot is written again.
- R8: `rd_en` with `rd_slot` gives `rd_valid` and that slot's trigger and payload on the next cycle. A read of the slot being written in the same cycle returns the contents from before the write.
- R9: After reset every index way is empty, every log slot holds trigger 0 and payload 0, and no lookup response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Record write offered |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_trigger | input | ADDR_W | Trigger block address of the record |
| wr_payload | input | PAY_W | Record payload |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_addr | input | ADDR_W | Block address to look up |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_rsp_hit | output | 1 | Lookup found the address |
| lk_rsp_slot | output | SLOT_W | Log slot for a hit, 0 on a miss |
| rd_en | input | 1 | Read a log slot |
| rd_slot | input | SLOT_W | Slot to read |
| rd_valid | output | 1 | Read data valid |
| rd_trigger | output | ADDR_W | Trigger stored in the slot |
| rd_payload | output | PAY_W | Payload stored in the slot |

## Verification
The bench runs a fixed sequence of writes and lookups. It covers these cases:
- Lookups before and after a trigger is first written, which tells a miss from a hit.
- A repeated write of the same trigger, which tells re-pointing apart from a fresh allocation.
- A third trigger written into a full set after one of the two entries was touched by a lookup. This separates true LRU from a fill-order or first-way choice.
- Writes that wrap the tail past the last slot, followed by lookups and reads of overwritten slots, which expose wrap errors and the stale entry that is kept.
- A write, a lookup and a read of the tail slot offered in one cycle, which checks write priority and read-before-write ordering.

// File: rtl/thl_pkg.sv
package thl_pkg;
  // Operation presented to the index in a given cycle
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_LOOKUP = 2'd1,
    OP_WRITE  = 2'd2
  } idx_op_e;
endpackage

// File: rtl/thl_lru_set.sv
// True-LRU state of one index set, kept as a per-way age rank (0 = newest).
module thl_lru_set #(
  parameter int WAYS = 2,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [WW-1:0] touch_way,
  output logic [WW-1:0] oldest_way
);
  logic [WW-1:0] age_q [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= WW'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == touch_way)             age_q[w] <= '0;
        else if (age_q[w] < age_q[touch_way]) age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[w] == WW'(WAYS - 1)) oldest_way = WW'(w);
  end
endmodule

// File: rtl/thl_ring.sv
// Circular log storage: tail pointer, write at tail, registered read port.
module thl_ring #(
  parameter int ADDR_W = 12,
  parameter int PAY_W  = 8,
  parameter int DEPTH  = 8,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_trigger,
  input  logic [PAY_W-1:0]  wr_payload,
  output logic [SLOT_W-1:0] tail,
  input  logic              rd_en,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_trigger,
  output logic [PAY_W-1:0]  rd_payload
);
  logic [ADDR_W-1:0] trig_q [DEPTH];
  logic [PAY_W-1:0]  pay_q  [DEPTH];
  logic [SLOT_W-1:0] tail_q;

  assign tail = tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        trig_q[i] <= '0;
        pay_q[i]  <= '0;
      end
    end else if (wr_en) begin
      trig_q[tail_q] <= wr_trigger;
      pay_q[tail_q]  <= wr_payload;
      tail_q <= (tail_q == SLOT_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    end
  end

  // Read samples the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_trigger <= '0;
      rd_payload <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_trigger <= trig_q[rd_slot];
        rd_payload <= pay_q[rd_slot];
      end
    end
  end
endmodule

// File: rtl/thl_index.sv
// Set-associative trigger index: tag match, fill-way choice, slot pointers.
module thl_index
  import thl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SLOT_W = 3,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W,
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  idx_op_e           op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [SLOT_W-1:0] op_slot,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot
);
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [SLOT_W-1:0] slot_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];

  logic [SET_W-1:0] set_sel;
  logic [TAG_W-1:0] tag_in;
  logic [WW-1:0]    hit_way, free_way, fill_way;
  logic             have_free, do_touch;
  logic [WW-1:0]    oldest [SETS];
  logic [SETS-1:0]  touch_set;

  assign set_sel = op_addr[SET_W-1:0];
  assign tag_in  = op_addr[ADDR_W-1:SET_W];

  always_comb begin
    hit       = 1'b0;
    hit_way   = '0;
    hit_slot  = '0;
    have_free = 1'b0;
    free_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[set_sel][w] && tag_q[set_sel][w] == tag_in) begin
        hit      = 1'b1;
        hit_way  = WW'(w);
        hit_slot = slot_q[set_sel][w];
      end
      if (!vld_q[set_sel][w] && !have_free) begin
        have_free = 1'b1;
        free_way  = WW'(w);
      end
    end
  end

  assign fill_way = hit ? hit_way : (have_free ? free_way : oldest[set_sel]);
  assign do_touch = (op == OP_WRITE) || (op == OP_LOOKUP && hit);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    assign touch_set[s] = do_touch && (set_sel == SET_W'(s));
    thl_lru_set #(.WAYS(WAYS)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      (touch_set[s]),
      .touch_way  (fill_way),
      .oldest_way (oldest[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          slot_q[s][w] <= '0;
        end
      end
    end else if (op == OP_WRITE) begin
      vld_q[set_sel][fill_way]  <= 1'b1;
      tag_q[set_sel][fill_way]  <= tag_in;
      slot_q[set_sel][fill_way] <= op_slot;
    end
  end
endmodule

// File: rtl/trig_history_log.sv
module trig_history_log
  import thl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAY_W    = 8,
  parameter int HB_DEPTH = 8,
  parameter int IDX_SETS = 4,
  parameter int IDX_WAYS = 2,
  localparam int SLOT_W  = $clog2(HB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_trigger,
  input  logic [PAY_W-1:0]  wr_payload,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_rsp_valid,
  output logic              lk_rsp_hit,
  output logic [SLOT_W-1:0] lk_rsp_slot,
  input  logic              rd_en,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_trigger,
  output logic [PAY_W-1:0]  rd_payload
);
  logic              lk_fire;
  logic [SLOT_W-1:0] tail_slot;
  idx_op_e           op;
  logic [ADDR_W-1:0] op_addr;
  logic              idx_hit;
  logic [SLOT_W-1:0] idx_slot;

  // Writes never stall and win the shared index over lookups
  assign wr_ready = 1'b1;
  assign lk_ready = !wr_valid;
  assign lk_fire  = lk_valid && !wr_valid;

  assign op      = wr_valid ? OP_WRITE : (lk_fire ? OP_LOOKUP : OP_IDLE);
  assign op_addr = wr_valid ? wr_trigger : lk_addr;

  thl_ring #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .DEPTH(HB_DEPTH)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_valid),
    .wr_trigger (wr_trigger),
    .wr_payload (wr_payload),
    .tail       (tail_slot),
    .rd_en      (rd_en),
    .rd_slot    (rd_slot),
    .rd_valid   (rd_valid),
    .rd_trigger (rd_trigger),
    .rd_payload (rd_payload)
  );

  thl_index #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SETS(IDX_SETS), .WAYS(IDX_WAYS)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .op_addr  (op_addr),
    .op_slot  (tail_slot),
    .hit      (idx_hit),
    .hit_slot (idx_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_rsp_valid <= 1'b0;
      lk_rsp_hit   <= 1'b0;
      lk_rsp_slot  <= '0;
    end else begin
      lk_rsp_valid <= lk_fire;
      lk_rsp_hit   <= lk_fire && idx_hit;
      lk_rsp_slot  <= (lk_fire && idx_hit) ? idx_slot : '0;
    end
  end
endmodule

// File: rtl/thl_checker.sv
module thl_checker #(
  parameter int ADDR_W   = 12,
  parameter int HB_DEPTH = 8,
  parameter int SLOT_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_trigger,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_rsp_valid,
  input logic              lk_rsp_hit,
  input logic [SLOT_W-1:0] lk_rsp_slot,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [SLOT_W-1:0] tail
);
  assert_tail_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> tail == (($past(tail) == SLOT_W'(HB_DEPTH - 1)) ? '0 : $past(tail) + 1'b1));

  assert_tail_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(tail));

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid ##1 (lk_valid && lk_ready && lk_addr == $past(wr_trigger))
      |=> lk_rsp_hit && lk_rsp_slot == $past(tail, 2));

  assert_rsp_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> lk_rsp_valid);

  assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !lk_rsp_valid);

  assert_miss_slot_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rsp_valid && !lk_rsp_hit) |-> lk_rsp_slot == '0);

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready && !lk_ready);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

bind trig_history_log thl_checker #(
  .ADDR_W(ADDR_W), .HB_DEPTH(HB_DEPTH), .SLOT_W(SLOT_W)
) u_thl_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_trigger   (wr_trigger),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .lk_addr      (lk_addr),
  .lk_rsp_valid (lk_rsp_valid),
  .lk_rsp_hit   (lk_rsp_hit),
  .lk_rsp_slot  (lk_rsp_slot),
  .rd_en        (rd_en),
  .rd_valid     (rd_valid),
  .tail         (tail_slot)
);

// File: tb/sim_trig_history_log.sv
`timescale 1ns/1ps
module sim_trig_history_log;
  localparam int ADDR_W = 12;
  localparam int PAY_W  = 8;
  localparam int SLOT_W = 3;
  localparam int NVEC   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, lk_valid = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_trigger = '0, lk_addr = '0;
  logic [PAY_W-1:0]  wr_payload = '0;
  logic [SLOT_W-1:0] rd_slot = '0;
  logic wr_ready, lk_ready, lk_rsp_valid, lk_rsp_hit, rd_valid;
  logic [SLOT_W-1:0] lk_rsp_slot;
  logic [ADDR_W-1:0] rd_trigger;
  logic [PAY_W-1:0]  rd_payload;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  trig_history_log u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_trigger(wr_trigger), .wr_payload(wr_payload),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_hit(lk_rsp_hit), .lk_rsp_slot(lk_rsp_slot),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_valid(rd_valid),
    .rd_trigger(rd_trigger), .rd_payload(rd_payload)
  );

  // Vector: {is_write, addr[11:0], exp_hit, exp_slot[2:0]}; set = addr[1:0], 4 sets x 2 ways, 8 slots
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 12'h010, 1'b0, 3'd0},  //  0 R4 miss before any write
    {1'b1, 12'h010, 1'b0, 3'd0},  //  1 write -> slot0 (R1)
    {1'b0, 12'h010, 1'b1, 3'd0},  //  2 R4 hit slot0
    {1'b1, 12'h020, 1'b0, 3'd0},  //  3 write -> slot1, set0 empty way (R3)
    {1'b1, 12'h010, 1'b0, 3'd0},  //  4 rewrite -> slot2 (R2)
    {1'b0, 12'h010, 1'b1, 3'd2},  //  5 R2 re-pointed to slot2
    {1'b0, 12'h020, 1'b1, 3'd1},  //  6 hit, makes 0x020 newest (R5)
    {1'b1, 12'h030, 1'b0, 3'd0},  //  7 write -> slot3, evicts LRU 0x010 (R3)
    {1'b0, 12'h010, 1'b0, 3'd0},  //  8 R5 R3 0x010 evicted
    {1'b0, 12'h020, 1'b1, 3'd1},  //  9 R5 0x020 kept
    {1'b0, 12'h030, 1'b1, 3'd3},  // 10 R3 new entry
    {1'b1, 12'h041, 1'b0, 3'd0},  // 11 write -> slot4
    {1'b0, 12'h041, 1'b1, 3'd4},  // 12 R1 slot4
    {1'b0, 12'h040, 1'b0, 3'd0},  // 13 R3 same set, other tag: miss
    {1'b1, 12'h012, 1'b0, 3'd0},  // 14 -> slot5
    {1'b1, 12'h013, 1'b0, 3'd0},  // 15 -> slot6
    {1'b1, 12'h022, 1'b0, 3'd0},  // 16 -> slot7
    {1'b1, 12'h051, 1'b0, 3'd0},  // 17 -> slot0 after wrap (R1)
    {1'b0, 12'h051, 1'b1, 3'd0},  // 18 R1 wrap to slot0
    {1'b0, 12'h012, 1'b1, 3'd5},  // 19 R1 slot5
    {1'b1, 12'h061, 1'b0, 3'd0},  // 20 -> slot1, evicts 0x041 (R3)
    {1'b0, 12'h020, 1'b1, 3'd1},  // 21 R7 stale pointer to slot1 kept
    {1'b0, 12'h041, 1'b0, 3'd0},  // 22 R3 0x041 evicted
    {1'b0, 12'h061, 1'b1, 3'd1}   // 23 R1 slot1
  };

  function automatic logic [PAY_W-1:0] pay_of(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [SLOT_W-1:0] s, input logic [ADDR_W-1:0] et, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_slot = s;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8", "rd_valid", 32'(rd_valid), 32'd1);
    chk(req, "rd_trigger", 32'(rd_trigger), 32'(et));
    chk(req, "rd_payload", 32'(rd_payload), (et == '0) ? 32'd0 : 32'(pay_of(et)));
    @(negedge clk);
    chk("R8", "rd_valid drop", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state, R6 ready levels when idle
    chk("R9", "lk_rsp_valid", 32'(lk_rsp_valid), 32'd0);
    chk("R6", "wr_ready", 32'(wr_ready), 32'd1);
    chk("R6", "lk_ready idle", 32'(lk_ready), 32'd1);
    do_read(3'd5, 12'h000, "R9");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] v;
      v = VEC[i];
      @(negedge clk);
      if (v[16]) begin
        wr_valid = 1'b1; wr_trigger = v[15:4]; wr_payload = pay_of(v[15:4]);
        @(negedge clk);
        wr_valid = 1'b0;
      end else begin
        lk_valid = 1'b1; lk_addr = v[15:4];
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R4", $sformatf("vec%0d rsp_valid", i), 32'(lk_rsp_valid), 32'd1);
        chk("R4", $sformatf("vec%0d hit", i), 32'(lk_rsp_hit), 32'(v[3]));
        chk("R4", $sformatf("vec%0d slot", i), 32'(lk_rsp_slot), 32'(v[2:0]));
        @(negedge clk);
        chk("R4", $sformatf("vec%0d rsp one cycle", i), 32'(lk_rsp_valid), 32'd0);
      end
    end

    // R1 wrap contents, R7 older record still readable in a stale slot
    do_read(3'd0, 12'h051, "R1");
    do_read(3'd1, 12'h061, "R7");
    do_read(3'd4, 12'h041, "R7");

    // R6 write priority with R8 read of tail slot (slot2, holds 0x010) in same cycle
    @(negedge clk);
    wr_valid = 1'b1; wr_trigger = 12'h077; wr_payload = pay_of(12'h077);
    lk_valid = 1'b1; lk_addr = 12'h030;
    rd_en = 1'b1; rd_slot = 3'd2;
    #1;
    chk("R6", "lk_ready under write", 32'(lk_ready), 32'd0);
    @(negedge clk);
    wr_valid = 1'b0; lk_valid = 1'b0; rd_en = 1'b0;
    chk("R6", "no rsp for refused lookup", 32'(lk_rsp_valid), 32'd0);
    chk("R8", "read-before-write trigger", 32'(rd_trigger), 32'h010);
    do_read(3'd2, 12'h077, "R8");

    // R2 written trigger visible at slot2
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 12'h077;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R2", "new hit", 32'(lk_rsp_hit), 32'd1);
    chk("R2", "new slot", 32'(lk_rsp_slot), 32'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule